// File: doc/BRIEF.md
# UART Control Register Bank with Guarded Writes

This block is the register front end of one UART channel. It stores the interrupt enable, FIFO control, modem control and extended-control registers, plus the two bytes of the baud divisor. It exports their stored values, along with a few decoded control bits, to the rest of the channel. Software reaches the bank through a plain port: a write strobe with an address and a data byte, and a separate read address that returns the stored byte combinationally.

Two guards filter the writes. The first is the unlock bit, bit 4 of the extended-control register. While it is clear, the upper control fields of three registers ignore written data and keep their previous contents. Those fields are interrupt enable bits 7:4, FIFO control bits 5:4 and modem control bits 7:5. The lower bits of each register still take every write.

The second guard is the sleep bit, bit 4 of the interrupt enable register. While it is set, both divisor bytes are frozen. Because the sleep bit is itself one of the protected bits, it can only be changed after the unlock bit is set.

Top module: `uart_reg_guard`

## Requirements
- R1: After reset every register, the divisor and every decoded output read as 0.
- R2: With extended-control bit 4 clear, a write to address 0 (interrupt enable) updates bits 3:0 and leaves bits 7:4 at their previous value.
- R3: With extended-control bit 4 clear, a write to address 1 (FIFO control) updates bits 7:6 and 3:0 and leaves bits 5:4 at their previous value.
- R4: With extended-control bit 4 clear, a write to address 2 (modem control) updates bits 4:0 and leaves bits 7:5 at their previous value.
- R5: With extended-control bit 4 set, writes to addresses 0, 1 and 2 replace all eight bits.
- R6: With interrupt enable bit 4 clear, a write to address 4 sets divisor bits 7:0 and a write to address 5 sets divisor bits 15:8.
- R7: With interrupt enable bit 4 set, writes to addresses 4 and 5 leave the divisor unchanged.
- R8: Address 3 (extended control) always accepts all eight bits. Its decoded outputs are: flow-control mode = bits 3:0, unlock = bit 4, RTS flow enable = bit 6, CTS flow enable = bit 7. The sleep output equals interrupt enable bit 4.
- R9: rd_data returns the stored byte of the register at rd_addr in the same cycle, whether or not earlier writes were blocked. Addresses 0..5 map to IER, FCR, MCR, EFR, DLL and DLH. Addresses 6 and 7 read 0, and writes to them change nothing.
- R10: A write takes effect at the first rising clock edge with wr_en high. Without wr_en, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Stored value at rd_addr |
| ier_q | output | 8 | Interrupt enable register |
| fcr_q | output | 8 | FIFO control register |
| mcr_q | output | 8 | Modem control register |
| efr_q | output | 8 | Extended-control register |
| divisor | output | 16 | Baud divisor {high byte, low byte} |
| enh_unlock | output | 1 | Protected-field write enable (extended-control bit 4) |
| sleep_en | output | 1 | Sleep mode (interrupt enable bit 4) |
| swfc_mode | output | 4 | Software flow-control mode |
| cts_flow_en | output | 1 | CTS hardware flow control enable |
| rts_flow_en | output | 1 | RTS hardware flow control enable |

## Verification
The bench uses the default parameters: an 8-bit data path, a 3-bit address and the default protection masks. With a 3-bit address, two unmapped addresses (6 and 7) are reachable, so random traffic also covers ignored writes and zero reads. Because every protected field is only a few bits wide, random writes regularly hit each combination of unlock and sleep state, including a sleep bit set and later cleared while unlocked, which reopens the divisor.

// File: rtl/uart_reg_guard_pkg.sv
package uart_reg_guard_pkg;
  localparam int REG_COUNT = 6;

  typedef enum logic [2:0] {
    RA_IER = 3'd0,
    RA_FCR = 3'd1,
    RA_MCR = 3'd2,
    RA_EFR = 3'd3,
    RA_DLL = 3'd4,
    RA_DLH = 3'd5
  } reg_addr_e;

  localparam int UNLOCK_BIT = 4;
  localparam int SLEEP_BIT  = 4;
endpackage

// File: rtl/guarded_reg.sv
module guarded_reg #(
  parameter int              W         = 8,
  parameter logic [W-1:0]    PROT_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic         unlock,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] merged;

  always_comb begin
    if (unlock) merged = wdata;
    else        merged = (wdata & ~PROT_MASK) | (q & PROT_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= merged;
  end
endmodule

// File: rtl/divisor_latch.sv
module divisor_latch #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2,
  localparam int DIV_W = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBYTES-1:0] we_byte,
  input  logic              lock,
  input  logic [BYTE_W-1:0] wdata,
  output logic [DIV_W-1:0]  div
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        div[b*BYTE_W +: BYTE_W] <= '0;
      else if (we_byte[b] && !lock)
        div[b*BYTE_W +: BYTE_W] <= wdata;
    end
  end
endmodule

// File: rtl/reg_read_mux.sv
module reg_read_mux #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int NREG   = 6
) (
  input  logic [NREG-1:0][DATA_W-1:0] regs,
  input  logic [ADDR_W-1:0]           addr,
  output logic [DATA_W-1:0]           data
);
  always_comb begin
    data = '0;
    for (int i = 0; i < NREG; i++)
      if (addr == ADDR_W'(i)) data = regs[i];
  end
endmodule

// File: rtl/uart_reg_guard.sv
module uart_reg_guard
  import uart_reg_guard_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter int                ADDR_W   = 3,
  parameter logic [DATA_W-1:0] IER_PROT = 8'hF0,
  parameter logic [DATA_W-1:0] FCR_PROT = 8'h30,
  parameter logic [DATA_W-1:0] MCR_PROT = 8'hE0,
  localparam int               DIV_W    = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] ier_q,
  output logic [DATA_W-1:0] fcr_q,
  output logic [DATA_W-1:0] mcr_q,
  output logic [DATA_W-1:0] efr_q,
  output logic [DIV_W-1:0]  divisor,
  output logic              enh_unlock,
  output logic              sleep_en,
  output logic [3:0]        swfc_mode,
  output logic              cts_flow_en,
  output logic              rts_flow_en
);
  logic [REG_COUNT-1:0] wsel;
  logic [REG_COUNT-1:0][DATA_W-1:0] bank;

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_dec
    assign wsel[i] = wr_en && (wr_addr == ADDR_W'(i));
  end

  assign enh_unlock = efr_q[UNLOCK_BIT];
  assign sleep_en   = ier_q[SLEEP_BIT];

  guarded_reg #(.W(DATA_W), .PROT_MASK(IER_PROT)) u_ier (
    .clk(clk), .rst_n(rst_n), .we(wsel[RA_IER]), .unlock(enh_unlock),
    .wdata(wr_data), .q(ier_q));

  guarded_reg #(.W(DATA_W), .PROT_MASK(FCR_PROT)) u_fcr (
    .clk(clk), .rst_n(rst_n), .we(wsel[RA_FCR]), .unlock(enh_unlock),
    .wdata(wr_data), .q(fcr_q));

  guarded_reg #(.W(DATA_W), .PROT_MASK(MCR_PROT)) u_mcr (
    .clk(clk), .rst_n(rst_n), .we(wsel[RA_MCR]), .unlock(enh_unlock),
    .wdata(wr_data), .q(mcr_q));

  // Extended-control register: never guarded
  guarded_reg #(.W(DATA_W), .PROT_MASK('0)) u_efr (
    .clk(clk), .rst_n(rst_n), .we(wsel[RA_EFR]), .unlock(1'b1),
    .wdata(wr_data), .q(efr_q));

  divisor_latch #(.BYTE_W(DATA_W), .NBYTES(2)) u_div (
    .clk(clk), .rst_n(rst_n), .we_byte({wsel[RA_DLH], wsel[RA_DLL]}),
    .lock(sleep_en), .wdata(wr_data), .div(divisor));

  assign swfc_mode   = efr_q[3:0];
  assign rts_flow_en = efr_q[6];
  assign cts_flow_en = efr_q[7];

  assign bank[RA_IER] = ier_q;
  assign bank[RA_FCR] = fcr_q;
  assign bank[RA_MCR] = mcr_q;
  assign bank[RA_EFR] = efr_q;
  assign bank[RA_DLL] = divisor[DATA_W-1:0];
  assign bank[RA_DLH] = divisor[DIV_W-1:DATA_W];

  reg_read_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NREG(REG_COUNT)) u_rd (
    .regs(bank), .addr(rd_addr), .data(rd_data));
endmodule

// File: rtl/uart_reg_guard_chk.sv
module uart_reg_guard_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  localparam int DIV_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] ier_q,
  input logic [DATA_W-1:0] fcr_q,
  input logic [DATA_W-1:0] mcr_q,
  input logic [DATA_W-1:0] efr_q,
  input logic [DIV_W-1:0]  divisor
);
  assert_ier_guard_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(0) && !efr_q[4]) |=> ier_q[7:4] == $past(ier_q[7:4]));

  assert_fcr_guard_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(1) && !efr_q[4]) |=> fcr_q[5:4] == $past(fcr_q[5:4]));

  assert_mcr_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(2) && !efr_q[4]) |=> mcr_q[7:5] == $past(mcr_q[7:5]));

  assert_ier_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(0) && efr_q[4]) |=> ier_q == $past(wr_data));

  assert_div_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == ADDR_W'(4) || wr_addr == ADDR_W'(5)) && ier_q[4]) |=> $stable(divisor));

  assert_efr_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(3)) |=> efr_q == $past(wr_data));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(ier_q) && $stable(fcr_q) && $stable(mcr_q) && $stable(efr_q) && $stable(divisor)));
endmodule

bind uart_reg_guard uart_reg_guard_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .ier_q(ier_q), .fcr_q(fcr_q), .mcr_q(mcr_q), .efr_q(efr_q), .divisor(divisor));

// File: tb/tb_uart_reg_guard.sv
`timescale 1ns/1ps
module tb_uart_reg_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data, ier_q, fcr_q, mcr_q, efr_q;
  logic [15:0] divisor;
  logic enh_unlock, sleep_en, cts_flow_en, rts_flow_en;
  logic [3:0] swfc_mode;

  int checks = 0;
  int errors = 0;
  logic [7:0] m [0:5];

  always #10 clk = ~clk;

  uart_reg_guard dut (.*);

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] merge(input logic [7:0] old, input logic [7:0] d,
                                       input logic [7:0] prot, input logic unl);
    return unl ? d : ((d & ~prot) | (old & prot));
  endfunction

  task automatic model_write(input logic [2:0] a, input logic [7:0] d);
    logic unl = m[3][4];
    logic slp = m[0][4];
    case (a)
      3'd0: m[0] = merge(m[0], d, 8'hF0, unl);
      3'd1: m[1] = merge(m[1], d, 8'h30, unl);
      3'd2: m[2] = merge(m[2], d, 8'hE0, unl);
      3'd3: m[3] = d;
      3'd4: if (!slp) m[4] = d;
      3'd5: if (!slp) m[5] = d;
      default: ;
    endcase
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic check_all();
    check("R2 ier", {8'h0, ier_q}, {8'h0, m[0]});
    check("R3 fcr", {8'h0, fcr_q}, {8'h0, m[1]});
    check("R4 mcr", {8'h0, mcr_q}, {8'h0, m[2]});
    check("R8 efr", {8'h0, efr_q}, {8'h0, m[3]});
    check("R6 divisor", divisor, {m[5], m[4]});
    check("R8 decode", {8'h0, cts_flow_en, rts_flow_en, enh_unlock, sleep_en, swfc_mode},
          {8'h0, m[3][7], m[3][6], m[3][4], m[0][4], m[3][3:0]});
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a);
      #1;
      check("R9 read", {8'h0, rd_data}, {8'h0, (a < 6) ? m[a] : 8'h00});
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) m[i] = 8'h00;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset ier", {8'h0, ier_q}, 16'h0);
    check("R1 reset div", divisor, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all();

    // R2/R3/R4 blocked writes while locked
    do_write(3'd0, 8'hFF); check("R2 locked ier", {8'h0, ier_q}, 16'h000F);
    do_write(3'd1, 8'hFF); check("R3 locked fcr", {8'h0, fcr_q}, 16'h00CF);
    do_write(3'd2, 8'hFF); check("R4 locked mcr", {8'h0, mcr_q}, 16'h001F);
    // R6 divisor open
    do_write(3'd4, 8'h34); do_write(3'd5, 8'h12);
    check("R6 divisor", divisor, 16'h1234);
    // R5 unlock then full writes
    do_write(3'd3, 8'h10);
    do_write(3'd0, 8'hF0); check("R5 ier full", {8'h0, ier_q}, 16'h00F0);
    do_write(3'd2, 8'hE0); check("R5 mcr full", {8'h0, mcr_q}, 16'h00E0);
    // R7 sleep set -> divisor locked
    do_write(3'd4, 8'hAA); do_write(3'd5, 8'hBB);
    check("R7 locked div", divisor, 16'h1234);
    // relock, protected bits keep value (R2)
    do_write(3'd3, 8'h00);
    do_write(3'd0, 8'h00); check("R2 retain ier", {8'h0, ier_q}, 16'h00F0);
    // R9 unmapped write
    do_write(3'd6, 8'h55);
    // R10 no strobe: hold inputs without wr_en
    @(negedge clk); wr_addr = 3'd3; wr_data = 8'hFF;
    @(negedge clk);
    check("R10 no strobe", {8'h0, efr_q}, 16'h0000);
    check_all();

    // random traffic
    for (int n = 0; n < 400; n++) begin
      logic [2:0] a = 3'($urandom_range(0, 7));
      logic [7:0] d = 8'($urandom);
      if ($urandom_range(0, 9) < 8) do_write(a, d);
      else @(negedge clk);
      check_all();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule